// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block is the hazard control for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle it compares the source register numbers of the instructions in decode and execute with the destination register numbers held in the pipeline registers after execute and after memory. From those comparisons it drives the select lines of the two operand bypass multiplexers in execute. It also drives a registered select that routes a load's memory output straight into the data-memory write port of the store right behind it.

The block also catches a load whose result the next instruction needs as an execute operand. That value only exists at the end of the load's memory cycle, so the block holds the program counter and the fetch/decode register for one cycle and clears the controls going into execute. A store that needs the loaded value only as its write data is not held. That value reaches it in the memory stage through the memory-to-memory path.

The datapath registers and multiplexers are outside the block. It takes decoded register fields and per-stage flags, and returns selects and interlock strobes. The register file writes in the first half of a cycle and reads in the second, so a dependence between writeback and decode needs no path here.

Top module: `hazard_ctrl`

## Requirements
- R1: `fwd_a` is 2'b10 (take the execute result held after execute) when the instruction after execute writes a register (`mem_regwrite`=1), is not a load (`mem_memread`=0), and its `mem_rd` equals a nonzero `ex_rs`.
- R2: When R1's match is absent and no load after execute targets that register, `fwd_a` is 2'b01 (take the writeback value) if `wb_regwrite`=1 and `wb_rd` equals a nonzero `ex_rs`. Otherwise it is 2'b00 (register file value).
- R3: When both the post-execute and the writeback stage target the same source register, the post-execute stage wins. It gives 2'b10 for a non-load, and 2'b00 for a load, never 2'b01.
- R4: Register number 0 never produces a bypass select, a stall or a memory-to-memory select.
- R5: `fwd_b` follows the rules of R1 to R3 applied to `ex_rt`. Its output feeds both the second ALU operand and the store write data, so a store right after an ALU op gets that op's result.
- R6: While a load sits after execute and targets an execute source register, the select for that operand is 2'b00. The load data is not yet available to execute.
- R7: `stall` and `bubble` are 1 in the same cycle when execute holds a load (`ex_memread`=1, `ex_regwrite`=1) whose nonzero `ex_rd` equals `id_rs` with `id_rs_used`=1, or equals `id_rt` with `id_rt_used`=1 on a non-store.
- R8: A store in decode whose only match with the load in execute is its data register (`id_rt`, `id_is_store`=1) causes no stall.
- R9: One cycle after a store in execute meets a load after execute whose nonzero destination equals `ex_rt`, `mem_sd_fwd` is 1; otherwise it is 0, and it is 0 after reset.
- R10: No stall arises when execute holds no load, when its write flag is off, or when decode does not read the matching register.
- R11: A stage whose register-write flag is 0 never causes a bypass select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_rs_used | input | 1 | Decode instruction reads `id_rs` |
| id_rt_used | input | 1 | Decode instruction reads `id_rt` |
| id_is_store | input | 1 | Decode instruction is a store (`id_rt` is write data) |
| ex_rs | input | REG_W | First source register in execute |
| ex_rt | input | REG_W | Second source register in execute |
| ex_rd | input | REG_W | Destination register in execute |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| ex_is_store | input | 1 | Execute instruction is a store |
| mem_rd | input | REG_W | Destination in the post-execute register |
| mem_regwrite | input | 1 | Post-execute instruction writes a register |
| mem_memread | input | 1 | Post-execute instruction is a load |
| wb_rd | input | REG_W | Destination in the writeback register |
| wb_regwrite | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Select for the first ALU operand |
| fwd_b | output | 2 | Select for the second operand and store data |
| mem_sd_fwd | output | 1 | Registered: route load output into memory write data |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear control fields entering execute |

## Verification
The bench builds the block with the default five-bit register numbers, but draws every register field from 0 to 3. Matches between stages, double matches where priority decides, and the zero register therefore come up in most cycles rather than rarely. Random flag combinations cover loads, stores and disabled writes. Directed cases replay the ALU-load-store chain, the load followed by a dependent subtract, and the store that depends on a load only through its data.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel
);
  localparam logic [REG_W-1:0] ZERO = '0;

  logic hit_mem, hit_wb;
  fwd_sel_e pick;

  assign hit_mem = mem_we && (mem_rd != ZERO) && (mem_rd == src);
  assign hit_wb  = wb_we  && (wb_rd  != ZERO) && (wb_rd  == src);

  // younger stage first; a pending load blocks the older copy too
  always_comb begin
    if (hit_mem)     pick = mem_ld ? FWD_NONE : FWD_MEM;
    else if (hit_wb) pick = FWD_WB;
    else             pick = FWD_NONE;
  end

  assign sel = pick;
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  output logic             hold
);
  localparam logic [REG_W-1:0] ZERO = '0;

  logic ld_pending, need_rs, need_rt;

  assign ld_pending = ex_memread && ex_regwrite && (ex_rd != ZERO);
  assign need_rs    = id_rs_used && (id_rs == ex_rd);
  // store data is served later by the memory-to-memory path
  assign need_rt    = id_rt_used && !id_is_store && (id_rt == ex_rd);
  assign hold       = ld_pending && (need_rs || need_rt);
endmodule

// File: rtl/hz_mem_fwd.sv
module hz_mem_fwd #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ex_rt,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  output logic             sd_fwd
);
  localparam logic [REG_W-1:0] ZERO = '0;

  logic hit;
  assign hit = ex_is_store && mem_memread && mem_regwrite &&
               (mem_rd != ZERO) && (mem_rd == ex_rt);

  // both instructions advance one stage together, so the decision
  // is valid when the store reaches memory and the load writeback
  always_ff @(posedge clk) begin
    if (rst) sd_fwd <= 1'b0;
    else     sd_fwd <= hit;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_regwrite,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             mem_sd_fwd,
  output logic             stall,
  output logic             bubble
);
  localparam int N_OPND = 2;

  logic [REG_W-1:0] opnd_src [N_OPND];
  logic [1:0]       opnd_sel [N_OPND];
  logic             hold;

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    hz_src_fwd #(.REG_W(REG_W)) u_fwd (
      .src    (opnd_src[k]),
      .mem_rd (mem_rd),
      .mem_we (mem_regwrite),
      .mem_ld (mem_memread),
      .wb_rd  (wb_rd),
      .wb_we  (wb_regwrite),
      .sel    (opnd_sel[k])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hz_load_use #(.REG_W(REG_W)) u_lu (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_rs_used  (id_rs_used),
    .id_rt_used  (id_rt_used),
    .id_is_store (id_is_store),
    .ex_rd       (ex_rd),
    .ex_regwrite (ex_regwrite),
    .ex_memread  (ex_memread),
    .hold        (hold)
  );

  assign stall  = hold;
  assign bubble = hold;

  hz_mem_fwd #(.REG_W(REG_W)) u_mfwd (
    .clk          (clk),
    .rst          (rst),
    .ex_rt        (ex_rt),
    .ex_is_store  (ex_is_store),
    .mem_rd       (mem_rd),
    .mem_regwrite (mem_regwrite),
    .mem_memread  (mem_memread),
    .sd_fwd       (mem_sd_fwd)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_rt,
  input logic             id_rs_used,
  input logic             id_is_store,
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rt,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_memread,
  input logic             ex_is_store,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_regwrite,
  input logic             mem_memread,
  input logic             wb_regwrite,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             mem_sd_fwd,
  input logic             stall,
  input logic             bubble
);
  localparam logic [REG_W-1:0] ZERO = '0;

  a_r1_mem_bypass_a: assert property (@(posedge clk) disable iff (rst)
    (mem_regwrite && !mem_memread && mem_rd != ZERO && mem_rd == ex_rs)
      |-> fwd_a == 2'b10);

  a_r3_no_older_over_load: assert property (@(posedge clk) disable iff (rst)
    (mem_regwrite && mem_rd != ZERO && mem_rd == ex_rt) |-> fwd_b != 2'b01);

  a_r4_zero_src: assert property (@(posedge clk) disable iff (rst)
    (ex_rs == ZERO) |-> fwd_a == 2'b00);

  a_r6_load_blocks_b: assert property (@(posedge clk) disable iff (rst)
    (mem_memread && mem_regwrite && mem_rd != ZERO && mem_rd == ex_rt)
      |-> fwd_b == 2'b00);

  a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_memread && ex_rd != ZERO));

  a_r7_bubble_with_stall: assert property (@(posedge clk) disable iff (rst)
    bubble |-> stall);

  a_r8_store_data_free: assert property (@(posedge clk) disable iff (rst)
    (id_is_store && (!id_rs_used || id_rs != ex_rd) && id_rt == ex_rd)
      |-> !stall);

  a_r9_sd_origin: assert property (@(posedge clk) disable iff (rst)
    mem_sd_fwd |-> $past(ex_is_store && mem_memread && mem_rd == ex_rt
                         && mem_rd != ZERO));

  a_r11_no_write_no_wb: assert property (@(posedge clk) disable iff (rst)
    !wb_regwrite |-> (fwd_a != 2'b01 && fwd_b != 2'b01));
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .id_rt(id_rt), .id_rs_used(id_rs_used),
  .id_is_store(id_is_store), .id_rs(id_rs), .ex_rs(ex_rs), .ex_rt(ex_rt),
  .ex_rd(ex_rd), .ex_memread(ex_memread), .ex_is_store(ex_is_store),
  .mem_rd(mem_rd), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
  .wb_regwrite(wb_regwrite), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .mem_sd_fwd(mem_sd_fwd), .stall(stall), .bubble(bubble)
);

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_rs_used, id_rt_used, id_is_store;
  logic ex_regwrite, ex_memread, ex_is_store;
  logic mem_regwrite, mem_memread, wb_regwrite;
  logic [1:0] fwd_a, fwd_b;
  logic mem_sd_fwd, stall, bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hazard_ctrl #(.REG_W(REG_W)) u_hazard_ctrl (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int g_fwd(logic [REG_W-1:0] s);
    if (mem_regwrite && mem_rd != 0 && mem_rd == s) return mem_memread ? 0 : 2;
    if (wb_regwrite && wb_rd != 0 && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic int g_stall();
    if (!(ex_memread && ex_regwrite && ex_rd != 0)) return 0;
    return int'((id_rs_used && id_rs == ex_rd) ||
                (id_rt_used && !id_is_store && id_rt == ex_rd));
  endfunction

  function automatic int g_sd();
    return int'(ex_is_store && mem_memread && mem_regwrite &&
                mem_rd != 0 && mem_rd == ex_rt);
  endfunction

  task automatic idle();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_rs_used, id_rt_used, id_is_store} = '0;
    {ex_regwrite, ex_memread, ex_is_store} = '0;
    {mem_regwrite, mem_memread, wb_regwrite} = '0;
  endtask

  // inputs are set at the falling edge; this samples after the rising edge
  task automatic settle_and_check(string tag);
    int e_a, e_b, e_s, e_sd;
    e_a = g_fwd(ex_rs); e_b = g_fwd(ex_rt); e_s = g_stall(); e_sd = g_sd();
    @(posedge clk); #2;
    check({tag, " R1 R2 R3 R4 R6 R11 fwd_a"}, int'(fwd_a), e_a);
    check({tag, " R5 R6 fwd_b"}, int'(fwd_b), e_b);
    check({tag, " R7 R8 R10 stall"}, int'(stall), e_s);
    check({tag, " R7 bubble"}, int'(bubble), e_s);
    check({tag, " R9 mem_sd_fwd"}, int'(mem_sd_fwd), e_sd);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2 check("R9 reset value", int'(mem_sd_fwd), 0);
    @(negedge clk); rst = 1'b0;

    // ALU op -> load using it as base -> store of the loaded value
    @(negedge clk); idle();
    ex_rs = 5'd1; ex_rt = 5'd4; ex_is_store = 1; mem_rd = 5'd4;
    mem_regwrite = 1; mem_memread = 1; wb_rd = 5'd1; wb_regwrite = 1;
    settle_and_check("chain");
    check("R9 load to store data", int'(mem_sd_fwd), 1);
    check("R2 base from writeback", int'(fwd_a), 1);
    check("R6 no ex forward of load", int'(fwd_b), 0);

    // load then dependent subtract
    @(negedge clk); idle();
    ex_rd = 5'd1; ex_regwrite = 1; ex_memread = 1;
    id_rs = 5'd1; id_rs_used = 1; id_rt = 5'd5; id_rt_used = 1;
    settle_and_check("load-use");
    check("R7 load-use stall", int'(stall), 1);

    // store whose data register only matches the load
    @(negedge clk); id_rs = 5'd2; id_rt = 5'd1; id_is_store = 1;
    settle_and_check("store data");
    check("R8 store not stalled", int'(stall), 0);

    // zero register everywhere
    @(negedge clk); idle();
    ex_memread = 1; ex_regwrite = 1; id_rs_used = 1; id_rt_used = 1;
    mem_regwrite = 1; wb_regwrite = 1; ex_is_store = 1; mem_memread = 1;
    settle_and_check("zero reg");
    check("R4 zero stall", int'(stall), 0);
    check("R4 zero sd", int'(mem_sd_fwd), 0);

    // double match priority
    @(negedge clk); idle();
    ex_rs = 5'd3; ex_rt = 5'd3; mem_rd = 5'd3; wb_rd = 5'd3;
    mem_regwrite = 1; wb_regwrite = 1;
    settle_and_check("priority");
    check("R3 younger wins", int'(fwd_a), 2);
    check("R5 store data from alu", int'(fwd_b), 2);

    // writes disabled
    @(negedge clk); mem_regwrite = 0; wb_regwrite = 0;
    ex_rd = 5'd3; id_rs = 5'd3; id_rs_used = 1; ex_memread = 1;
    settle_and_check("no write");
    check("R11 no forward", int'(fwd_a), 0);
    check("R10 no stall", int'(stall), 0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      id_rs = REG_W'($urandom % 4); id_rt = REG_W'($urandom % 4);
      ex_rs = REG_W'($urandom % 4); ex_rt = REG_W'($urandom % 4);
      ex_rd = REG_W'($urandom % 4); mem_rd = REG_W'($urandom % 4);
      wb_rd = REG_W'($urandom % 4);
      {id_rs_used, id_rt_used, id_is_store} = 3'($urandom);
      {ex_regwrite, ex_memread, ex_is_store} = 3'($urandom);
      {mem_regwrite, mem_memread, wb_regwrite} = 3'($urandom);
      settle_and_check("random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule